// File: doc/BRIEF.md
# Operand Access Mode Controller

This block carries out the operand-access step that follows effective-address computation in an instruction pipeline. For each instruction it receives a 3-bit access code from the opcode decoder, together with the effective address, the address of the current instruction and the current accumulator value. From these it either delivers an operand at once, or it issues one memory request and waits for the answer.

Some codes need no memory. They can return the address in local (short) form or in full-width form, and one of them also starts an early fetch of the following instruction. The other codes probe the target for write permission, read the operand, read and probe, or read under a lock. The lock is used only when the target is uncached. One read code also fetches the next instruction, but only after the operand has returned.

Completion is a one-cycle operand-ready strobe with the operand on a data bus. A page fault reported while the request is pending replaces that strobe with a one-cycle trap strobe. Only one memory request is ever outstanding. The instruction prefetch is a separate one-cycle strobe that carries the next instruction address.

Top module: `opacc_ctrl`

## Requirements
- R1: After reset, `opnd_ready`, `trap`, `pf_req`, `mem_req` and `busy` are all low.
- R2: Code 0. One cycle after `start` is sampled, `opnd_ready` pulses and `opnd_data` holds the low `LW` bits of `ea`, zero-extended. No memory request is made and no prefetch is issued.
- R3: Code 1. Behaves as R2, and in the same cycle as `opnd_ready` it pulses `pf_req` with `pf_addr` equal to `pc`+1, modulo 2^`AW`.
- R4: Code 2. One cycle after `start`, `opnd_ready` pulses with `opnd_data` equal to the full `AW`-bit `ea`, zero-extended. No memory request is made.
- R5: Codes 3 to 7 hold the memory request from the cycle after `start` until the cycle in which `mem_ack` or `page_fail` is sampled. During that time `mem_req` is high and `mem_addr` equals `ea`. The qualifiers are set as follows:
  - `mem_rd` is set for codes 4 to 7.
  - `mem_wtest` is set for codes 3, 6 and 7.
  - `mem_lock` is set only for code 7, and only when `uncached` was high at `start`. With `uncached` low, code 7 behaves like code 6.
- R6: Code 3. One cycle after `mem_ack` is sampled, `opnd_ready` pulses with `opnd_data` equal to `ac_val` as sampled together with `mem_ack`.
- R7: Codes 4, 5, 6 and 7. One cycle after `mem_ack` is sampled, `opnd_ready` pulses with `opnd_data` equal to `mem_rdata` as sampled together with `mem_ack`.
- R8: Code 5. `pf_req` (with `pf_addr` = `pc`+1) pulses only in the same cycle as `opnd_ready`, after the operand response. `pf_req` is never high while `mem_req` is high.
- R9: While a request is pending, `page_fail` takes priority over `mem_ack`. One cycle after it is sampled, `trap` pulses, `mem_req` drops, and neither `opnd_ready` nor `pf_req` is raised for that instruction.
- R10: While `busy` is high, `start` is ignored: the pending address and qualifiers are unchanged. While no request is pending, `mem_ack` and `page_fail` are ignored.
- R11: `opnd_ready` and `trap` are never high together, and each is high for exactly one cycle per completed instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin access step for one instruction (taken when not busy) |
| mode | input | 3 | Access code 0..7 |
| ea | input | AW | Effective address |
| pc | input | AW | Current instruction address |
| uncached | input | 1 | Target address is not cached |
| ac_val | input | DW | Accumulator value (operand for code 3) |
| mem_ack | input | 1 | Memory response for the pending request |
| mem_rdata | input | DW | Memory read data, valid with mem_ack |
| page_fail | input | 1 | Page fault for the pending request |
| mem_req | output | 1 | Memory request pending |
| mem_addr | output | AW | Request address |
| mem_rd | output | 1 | Request reads data |
| mem_wtest | output | 1 | Request probes write permission |
| mem_lock | output | 1 | Request is a locked read (first half of read-pause-write) |
| busy | output | 1 | Waiting on memory |
| opnd_ready | output | 1 | Operand ready strobe |
| opnd_data | output | DW | Operand / address result |
| trap | output | 1 | Page-fault trap strobe |
| pf_req | output | 1 | Instruction prefetch strobe |
| pf_addr | output | AW | Prefetch address (pc+1) |

## Verification
The bench uses the default widths: a 30-bit full address, an 18-bit local address and a 36-bit data word. These sizes make the local and full-width address results differ whenever the random address has upper bits set. They also let wrap-around of the incremented instruction address be reached with a directed all-ones value. Random memory latencies of zero to three cycles, random page faults, and start pulses issued mid-wait exercise the single-outstanding rule, the fault priority and the ordering of the late prefetch.

// File: rtl/opacc_pkg.sv
package opacc_pkg;

  typedef enum logic [2:0] {
    AM_NONE    = 3'd0,
    AM_NONE_PF = 3'd1,
    AM_WIDE    = 3'd2,
    AM_WCHK    = 3'd3,
    AM_RD      = 3'd4,
    AM_RD_PF   = 3'd5,
    AM_RDW     = 3'd6,
    AM_RMW     = 3'd7
  } amode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ost_e;

  typedef struct packed {
    logic mem;       // needs a memory request
    logic rd;        // request reads data
    logic wtest;     // request probes writability
    logic lockable;  // locked read when uncached
    logic pf_now;    // prefetch at dispatch
    logic pf_late;   // prefetch after operand arrives
    logic wide;      // return full address
    logic from_ac;   // operand is accumulator
  } actl_t;

endpackage

// File: rtl/opacc_decode.sv
module opacc_decode
  import opacc_pkg::*;
(
  input  logic [2:0] mode,
  output actl_t      ctl
);
  always_comb begin
    ctl = '0;
    case (amode_e'(mode))
      AM_NONE:    ctl = '0;
      AM_NONE_PF: ctl.pf_now = 1'b1;
      AM_WIDE:    ctl.wide = 1'b1;
      AM_WCHK: begin
        ctl.mem = 1'b1; ctl.wtest = 1'b1; ctl.from_ac = 1'b1;
      end
      AM_RD: begin
        ctl.mem = 1'b1; ctl.rd = 1'b1;
      end
      AM_RD_PF: begin
        ctl.mem = 1'b1; ctl.rd = 1'b1; ctl.pf_late = 1'b1;
      end
      AM_RDW: begin
        ctl.mem = 1'b1; ctl.rd = 1'b1; ctl.wtest = 1'b1;
      end
      AM_RMW: begin
        ctl.mem = 1'b1; ctl.rd = 1'b1; ctl.wtest = 1'b1; ctl.lockable = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/opacc_fsm.sv
module opacc_fsm
  import opacc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic need_mem,
  input  logic mem_ack,
  input  logic page_fail,
  output logic accept,
  output logic resp_ok,
  output logic resp_fail,
  output logic waiting
);
  ost_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    accept    = 1'b0;
    resp_ok   = 1'b0;
    resp_fail = 1'b0;
    case (st_q)
      ST_IDLE: begin
        accept = start;
        if (start && need_mem) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (page_fail) begin
          resp_fail = 1'b1;
          st_d      = ST_IDLE;
        end else if (mem_ack) begin
          resp_ok = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign waiting = (st_q == ST_WAIT);
endmodule

// File: rtl/opacc_data.sv
module opacc_data
  import opacc_pkg::*;
#(
  parameter int AW = 30,
  parameter int LW = 18,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          resp_ok,
  input  logic          resp_fail,
  input  actl_t         ctl,
  input  logic [AW-1:0] ea,
  input  logic [AW-1:0] pc,
  input  logic          uncached,
  input  logic [DW-1:0] ac_val,
  input  logic [DW-1:0] mem_rdata,
  output actl_t         ctl_q,
  output logic          lock_q,
  output logic [AW-1:0] ea_q,
  output logic [AW-1:0] pf_addr,
  output logic          opnd_ready,
  output logic [DW-1:0] opnd_data,
  output logic          trap,
  output logic          pf_req
);
  logic          rdy_d, trap_d, pf_d, dat_en;
  logic [DW-1:0] dat_d, ea_short, ea_full;

  always_comb begin
    ea_short           = '0;
    ea_short[LW-1:0]   = ea[LW-1:0];
    ea_full            = '0;
    ea_full[AW-1:0]    = ea;
    rdy_d  = (accept && !ctl.mem) || resp_ok;
    trap_d = resp_fail;
    pf_d   = (accept && ctl.pf_now) || (resp_ok && ctl_q.pf_late);
    dat_en = rdy_d;
    dat_d  = opnd_data;
    if (accept && !ctl.mem) dat_d = ctl.wide ? ea_full : ea_short;
    else if (resp_ok)       dat_d = ctl_q.from_ac ? ac_val : mem_rdata;
  end

  // Per-instruction context, captured on accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      lock_q  <= 1'b0;
      ea_q    <= '0;
      pf_addr <= '0;
    end else if (accept) begin
      ctl_q   <= ctl;
      lock_q  <= ctl.lockable && uncached;
      ea_q    <= ea;
      pf_addr <= pc + AW'(1);
    end
  end

  // Strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opnd_ready <= 1'b0;
      trap       <= 1'b0;
      pf_req     <= 1'b0;
    end else begin
      opnd_ready <= rdy_d;
      trap       <= trap_d;
      pf_req     <= pf_d;
    end
  end

  // Operand data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      opnd_data <= '0;
    else if (dat_en) opnd_data <= dat_d;
  end
endmodule

// File: rtl/opacc_ctrl.sv
module opacc_ctrl
  import opacc_pkg::*;
#(
  parameter int AW = 30,
  parameter int LW = 18,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] ea,
  input  logic [AW-1:0] pc,
  input  logic          uncached,
  input  logic [DW-1:0] ac_val,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  input  logic          page_fail,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wtest,
  output logic          mem_lock,
  output logic          busy,
  output logic          opnd_ready,
  output logic [DW-1:0] opnd_data,
  output logic          trap,
  output logic          pf_req,
  output logic [AW-1:0] pf_addr
);
  actl_t ctl, ctl_q;
  logic  accept, resp_ok, resp_fail, waiting, lock_q;
  logic [AW-1:0] ea_q;

  opacc_decode u_dec (
    .mode (mode),
    .ctl  (ctl)
  );

  opacc_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .need_mem  (ctl.mem),
    .mem_ack   (mem_ack),
    .page_fail (page_fail),
    .accept    (accept),
    .resp_ok   (resp_ok),
    .resp_fail (resp_fail),
    .waiting   (waiting)
  );

  opacc_data #(.AW(AW), .LW(LW), .DW(DW)) u_dat (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .resp_ok    (resp_ok),
    .resp_fail  (resp_fail),
    .ctl        (ctl),
    .ea         (ea),
    .pc         (pc),
    .uncached   (uncached),
    .ac_val     (ac_val),
    .mem_rdata  (mem_rdata),
    .ctl_q      (ctl_q),
    .lock_q     (lock_q),
    .ea_q       (ea_q),
    .pf_addr    (pf_addr),
    .opnd_ready (opnd_ready),
    .opnd_data  (opnd_data),
    .trap       (trap),
    .pf_req     (pf_req)
  );

  assign busy      = waiting;
  assign mem_req   = waiting;
  assign mem_addr  = ea_q;
  assign mem_rd    = waiting && ctl_q.rd;
  assign mem_wtest = waiting && ctl_q.wtest;
  assign mem_lock  = waiting && lock_q;
endmodule

// File: rtl/opacc_chk.sv
module opacc_chk #(
  parameter int AW = 30
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          page_fail,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_wtest,
  input logic          mem_lock,
  input logic          opnd_ready,
  input logic          trap,
  input logic          pf_req
);
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !page_fail) |=> (mem_req && $stable(mem_addr)));

  // R5
  lock_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_lock |-> (mem_req && mem_rd && mem_wtest));

  // R7
  ack_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !page_fail) |=> (opnd_ready && !trap && !mem_req));

  // R9
  fault_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && page_fail) |=> (trap && !opnd_ready && !pf_req && !mem_req));

  // R8
  pf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_req |-> !mem_req);

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(opnd_ready && trap));

  // R11
  trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> !trap);
endmodule

bind opacc_ctrl opacc_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req    (mem_req),
  .mem_ack    (mem_ack),
  .page_fail  (page_fail),
  .mem_addr   (mem_addr),
  .mem_rd     (mem_rd),
  .mem_wtest  (mem_wtest),
  .mem_lock   (mem_lock),
  .opnd_ready (opnd_ready),
  .trap       (trap),
  .pf_req     (pf_req)
);

// File: tb/opacc_ctrl_tb.sv
module opacc_ctrl_tb;
  localparam int AW = 30;
  localparam int LW = 18;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [2:0]    mode = '0;
  logic [AW-1:0] ea = '0, pc = '0;
  logic          uncached = 1'b0;
  logic [DW-1:0] ac_val = '0, mem_rdata = '0;
  logic          mem_ack = 1'b0, page_fail = 1'b0;
  logic          mem_req, mem_rd, mem_wtest, mem_lock, busy;
  logic          opnd_ready, trap, pf_req;
  logic [AW-1:0] mem_addr, pf_addr;
  logic [DW-1:0] opnd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  opacc_ctrl #(.AW(AW), .LW(LW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .ea(ea), .pc(pc),
    .uncached(uncached), .ac_val(ac_val), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .page_fail(page_fail), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wtest(mem_wtest),
    .mem_lock(mem_lock), .busy(busy), .opnd_ready(opnd_ready),
    .opnd_data(opnd_data), .trap(trap), .pf_req(pf_req), .pf_addr(pf_addr)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_imm(input logic [2:0] m, input logic [AW-1:0] a);
    logic [DW-1:0] r;
    r = '0;
    if (m == 3'd2) r[AW-1:0] = a;
    else           r[LW-1:0] = a[LW-1:0];
    return r;
  endfunction

  function automatic logic [2:0] exp_qual(input logic [2:0] m, input logic unc);
    // {rd, wtest, lock}
    logic rd, wt, lk;
    rd = (m >= 3'd4);
    wt = (m == 3'd3) || (m == 3'd6) || (m == 3'd7);
    lk = (m == 3'd7) && unc;
    return {rd, wt, lk};
  endfunction

  // One instruction. delay = cycles of waiting before response; fault selects page fail.
  task automatic run_op(input logic [2:0] m, input logic [AW-1:0] a,
                        input logic [AW-1:0] p, input logic unc,
                        input int delay, input bit fault, input bit poke);
    logic [AW-1:0] pexp;
    logic [DW-1:0] rd_v, ac_v;
    pexp = p + AW'(1);
    @(negedge clk);
    start = 1'b1; mode = m; ea = a; pc = p; uncached = unc;
    ac_val = DW'({$urandom, $urandom});
    @(negedge clk);
    start = 1'b0;
    ea = ~a; pc = ~p; uncached = ~unc;  // inputs no longer matter
    if (m < 3'd3) begin
      chk(opnd_ready === 1'b1, (m == 0) ? "R2 ready" : (m == 1) ? "R3 ready" : "R4 ready",
          64'(opnd_ready), 64'd1);
      chk(opnd_data === exp_imm(m, a), (m == 2) ? "R4 data" : "R2 data",
          64'(opnd_data), 64'(exp_imm(m, a)));
      chk(pf_req === (m == 3'd1), "R3 pf_req", 64'(pf_req), 64'(m == 3'd1));
      if (m == 3'd1) chk(pf_addr === pexp, "R3 pf_addr", 64'(pf_addr), 64'(pexp));
      chk(mem_req === 1'b0, "R2 no mem_req", 64'(mem_req), 64'd0);
      @(negedge clk);
      chk(opnd_ready === 1'b0, "R11 ready pulse", 64'(opnd_ready), 64'd0);
    end else begin
      chk(mem_req === 1'b1 && busy === 1'b1, "R5 req", 64'(mem_req), 64'd1);
      chk(mem_addr === a, "R5 addr", 64'(mem_addr), 64'(a));
      chk({mem_rd, mem_wtest, mem_lock} === exp_qual(m, unc), "R5 qual",
          64'({mem_rd, mem_wtest, mem_lock}), 64'(exp_qual(m, unc)));
      for (int i = 0; i < delay; i++) begin
        if (poke && i == 0) begin
          start = 1'b1; mode = 3'd0; ea = ~a;
        end
        @(negedge clk);
        start = 1'b0;
        chk(mem_req === 1'b1 && mem_addr === a, "R10 start ignored while busy",
            64'(mem_addr), 64'(a));
        chk({mem_rd, mem_wtest, mem_lock} === exp_qual(m, unc), "R5 qual held",
            64'({mem_rd, mem_wtest, mem_lock}), 64'(exp_qual(m, unc)));
        chk(pf_req === 1'b0 && opnd_ready === 1'b0, "R8 no pf while waiting",
            64'(pf_req), 64'd0);
      end
      rd_v = DW'({$urandom, $urandom});
      ac_v = DW'({$urandom, $urandom});
      mem_rdata = rd_v; ac_val = ac_v;
      if (fault) begin
        page_fail = 1'b1;
        mem_ack = ($urandom % 2) == 0;  // fault wins over ack
      end else begin
        mem_ack = 1'b1;
      end
      @(negedge clk);
      mem_ack = 1'b0; page_fail = 1'b0;
      mem_rdata = ~rd_v; ac_val = ~ac_v;
      chk(mem_req === 1'b0, "R9 req drops", 64'(mem_req), 64'd0);
      if (fault) begin
        chk(trap === 1'b1 && opnd_ready === 1'b0, "R9 trap", 64'({trap, opnd_ready}), 64'b10);
        chk(pf_req === 1'b0, "R9 no pf", 64'(pf_req), 64'd0);
      end else begin
        chk(opnd_ready === 1'b1 && trap === 1'b0, "R7 ready", 64'({opnd_ready, trap}), 64'b10);
        if (m == 3'd3)
          chk(opnd_data === ac_v, "R6 ac data", 64'(opnd_data), 64'(ac_v));
        else
          chk(opnd_data === rd_v, "R7 mem data", 64'(opnd_data), 64'(rd_v));
        chk(pf_req === (m == 3'd5), "R8 late pf", 64'(pf_req), 64'(m == 3'd5));
        if (m == 3'd5) chk(pf_addr === pexp, "R8 pf_addr", 64'(pf_addr), 64'(pexp));
      end
      @(negedge clk);
      chk(opnd_ready === 1'b0 && trap === 1'b0, "R11 single pulse",
          64'({opnd_ready, trap}), 64'd0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk({opnd_ready, trap, pf_req, mem_req, busy} === 5'b0, "R1 reset",
        64'({opnd_ready, trap, pf_req, mem_req, busy}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({opnd_ready, trap, pf_req, mem_req, busy} === 5'b0, "R1 after release",
        64'({opnd_ready, trap, pf_req, mem_req, busy}), 64'd0);

    // R10: responses while idle are ignored
    mem_ack = 1'b1; page_fail = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0; page_fail = 1'b0;
    @(negedge clk);
    chk({trap, opnd_ready, mem_req} === 3'b0, "R10 idle response ignored",
        64'({trap, opnd_ready, mem_req}), 64'd0);

    // Directed corners
    run_op(3'd0, 30'h3FFF_FFFF, 30'h0, 1'b0, 0, 1'b0, 1'b0);       // R2
    run_op(3'd1, 30'h2AAA_5555, 30'h3FFF_FFFF, 1'b0, 0, 1'b0, 1'b0); // R3 wrap
    run_op(3'd2, 30'h3FFF_FFFF, 30'h10, 1'b0, 0, 1'b0, 1'b0);      // R4
    run_op(3'd3, 30'h0001_2345, 30'h20, 1'b0, 2, 1'b0, 1'b0);      // R6
    run_op(3'd7, 30'h0ABC_DEF0, 30'h30, 1'b1, 1, 1'b0, 1'b0);      // R5 lock
    run_op(3'd7, 30'h0ABC_DEF0, 30'h30, 1'b0, 1, 1'b0, 1'b0);      // R5 cached
    run_op(3'd5, 30'h1234_5678, 30'h3FFF_FFFF, 1'b0, 0, 1'b0, 1'b0); // R8
    run_op(3'd5, 30'h1234_5678, 30'h44, 1'b0, 2, 1'b1, 1'b1);      // R9 + R10
    run_op(3'd6, 30'h0000_0001, 30'h50, 1'b1, 3, 1'b0, 1'b1);      // R7 + R10

    // Random mix
    for (int k = 0; k < 400; k++) begin
      run_op(3'($urandom), AW'($urandom), AW'($urandom), 1'($urandom),
             int'($urandom % 4), ($urandom % 8) == 0, ($urandom % 4) == 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule